// File: doc/BRIEF.md
# Banked Register File Operand Collector

This block gathers the source operands of instructions from a register file that is split into single-ported banks. Each accepted instruction takes one free collector unit. The unit holds up to three operand slots, and each slot asks the bank that owns its register for a read. Every bank serves one read per cycle. Reads to different banks go ahead in parallel, and a read that loses a bank conflict stays queued in its collector until a later cycle. Returned data is latched into the slot. A collector whose operands are all present hands the whole set to the execution stage and then becomes free again.

The register contents are a read-only model computed inside the block, so the block can be tested without write ports. Register `r` of warp `w` lives in bank `(w + r) mod 4`. Consecutive registers of one warp therefore spread across the banks, and the same register number of neighbouring warps also lands in different banks. When several collectors are ready at the same time they leave one per cycle, oldest first.

Top module: `oc_collector_top`

## Requirements
- R1: While `rst_n` is low and directly after it is released, every collector is free: `in_ready` is 1 and `out_valid` is 0.
- R2: Register `r` (4 bits) of warp `w` (2 bits) is held in bank `(w + r) mod 4`. Each of the four banks performs at most one read per cycle, and reads to different banks in the same cycle all proceed.
- R3: The modelled contents of register `r` of warp `w` are `({w, r} * 32'h01030507) mod 2^32`, where `{w, r}` is the 6-bit value with `w` in the upper two bits.
- R4: When several collectors want the same bank, that bank grants them in round-robin order, starting after the collector it granted last.
- R5: Read data comes back one cycle after the grant and fills the slot. A slot that loses a conflict waits in its collector. With no other traffic, an instruction accepted at rising edge E, whose most-used bank is named by k of its valid sources, shows `out_valid` after edge E+2+k. With k = 0 this is edge E+1.
- R6: An instruction is dispatched only when every valid slot holds its data. Slot i occupies `out_ops[32*i+31:32*i]` and `in_src_regs[4*i+3:4*i]`. A slot whose bit in `in_src_valid` is 0 ignores its register number, costs no read and gives zero in `out_ops`.
- R7: `in_ready` is 1 whenever at least one collector is free. An instruction is taken on a rising edge with `in_valid` and `in_ready` both 1. `in_valid` is ignored while `in_ready` is 0.
- R8: Four collectors exist, so four instructions can wait at once. With all four busy, `in_ready` is 0.
- R9: Complete collectors dispatch one per cycle, oldest accepted first. Each instruction gives exactly one cycle of `out_valid`, with its own `out_tag`, `out_warp` and `out_src_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | A collector unit is free |
| in_warp | input | 2 | Warp of the offered instruction |
| in_tag | input | 4 | Identifier carried through to dispatch |
| in_src_valid | input | 3 | Per-slot flag: source in use |
| in_src_regs | input | 12 | Three 4-bit source register numbers, slot 0 lowest |
| out_valid | output | 1 | Complete operand set dispatched this cycle |
| out_tag | output | 4 | Identifier of the dispatched instruction |
| out_warp | output | 2 | Warp of the dispatched instruction |
| out_src_valid | output | 3 | Slot flags of the dispatched instruction |
| out_ops | output | 96 | Three 32-bit operands, slot 0 lowest |

## Verification
The bench sends single instructions whose sources pile onto one bank, spread across banks, repeat the same register, or are partly invalid. It checks operand values and the exact cycle of dispatch. A design that reads a bank twice in one cycle, or that charges reads for invalid slots, shows up there as the wrong latency or non-zero data. Two collectors that fight over one bank must alternate. A fixed-priority arbiter lets the first instruction finish two cycles early and is caught that way. Two collectors that complete in the same cycle must leave in order of age. A full set of four collectors must refuse a fifth offer, which must never appear at the output.

// File: rtl/oc_pkg.sv
package oc_pkg;
    localparam int NUM_BANKS = 4;
    localparam int NUM_CU    = 4;
    localparam int NUM_SLOTS = 3;
    localparam int WARP_W    = 2;
    localparam int REG_W     = 4;
    localparam int DATA_W    = 32;
    localparam int TAG_W     = 4;

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int CU_W   = $clog2(NUM_CU);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam logic [31:0] FILL_MUL = 32'h0103_0507;

    typedef struct packed {
        logic              vld;
        logic              rdy;
        logic              pend;
        logic [REG_W-1:0]  rnum;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        logic                        busy;
        logic [WARP_W-1:0]           warp;
        logic [TAG_W-1:0]            tag;
        logic [CU_W-1:0]             age;
        slot_t [NUM_SLOTS-1:0]       slot;
    } cu_t;

    typedef struct packed {
        logic              vld;
        logic [CU_W-1:0]   cu;
        logic [SLOT_W-1:0] slot;
        logic [DATA_W-1:0] data;
    } rd_t;

    function automatic logic [BANK_W-1:0] bank_of(input logic [WARP_W-1:0] w,
                                                  input logic [REG_W-1:0]  r);
        logic [REG_W:0] sum;
        sum = {1'b0, r} + (REG_W+1)'(w);
        return sum[BANK_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] reg_value(input logic [WARP_W-1:0] w,
                                                    input logic [REG_W-1:0]  r);
        logic [31:0] idx;
        idx = 32'({w, r});
        return DATA_W'(idx * FILL_MUL);
    endfunction
endpackage

// File: rtl/oc_rr_arb.sv
module oc_rr_arb #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic             gnt_any,
    output logic [IDX_W-1:0] gnt_idx
);
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic [N-1:0]     gnt;
    logic [IDX_W-1:0] idx;

    // search starts one past the last winner
    always_comb begin
        gnt     = '0;
        gnt_any = 1'b0;
        gnt_idx = '0;
        ptr_d   = ptr_q;
        idx     = '0;
        for (int i = 1; i <= N; i++) begin
            idx = IDX_W'((int'(ptr_q) + i) % N);
            if (!gnt_any && req[idx]) begin
                gnt[idx] = 1'b1;
                gnt_any  = 1'b1;
                gnt_idx  = idx;
                ptr_d    = idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // R2: one read per bank per cycle
    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R4: a grant only goes to a requester
    assert_grant_to_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
endmodule

// File: rtl/oc_bank_port.sv
module oc_bank_port
    import oc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [CU_W-1:0]   rd_cu,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [WARP_W-1:0] rd_warp,
    input  logic [REG_W-1:0]  rd_reg,
    output rd_t               ret_q
);
    rd_t ret_d;

    always_comb begin
        ret_d.vld  = rd_en;
        ret_d.cu   = rd_cu;
        ret_d.slot = rd_slot;
        ret_d.data = rd_en ? reg_value(rd_warp, rd_reg) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ret_q <= '0;
        else        ret_q <= ret_d;
    end
endmodule

// File: rtl/oc_collector_top.sv
module oc_collector_top
    import oc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [WARP_W-1:0]           in_warp,
    input  logic [TAG_W-1:0]            in_tag,
    input  logic [NUM_SLOTS-1:0]        in_src_valid,
    input  logic [NUM_SLOTS*REG_W-1:0]  in_src_regs,
    output logic                        out_valid,
    output logic [TAG_W-1:0]            out_tag,
    output logic [WARP_W-1:0]           out_warp,
    output logic [NUM_SLOTS-1:0]        out_src_valid,
    output logic [NUM_SLOTS*DATA_W-1:0] out_ops
);
    typedef struct packed {
        cu_t [NUM_CU-1:0]            cu;
        logic                        ov;
        logic [TAG_W-1:0]            otag;
        logic [WARP_W-1:0]           owarp;
        logic [NUM_SLOTS-1:0]        osrcv;
        logic [NUM_SLOTS*DATA_W-1:0] oops;
    } st_t;

    st_t st_q, st_d;

    logic [NUM_CU-1:0] busy_v, done_v, oldest_v;
    logic [NUM_CU-1:0] req [NUM_BANKS];
    logic [SLOT_W-1:0] rslot [NUM_CU][NUM_BANKS];
    logic [NUM_BANKS-1:0] gany;
    logic [CU_W-1:0]   gcu [NUM_BANKS];
    rd_t               ret [NUM_BANKS];

    logic              dsp, take;
    logic [CU_W-1:0]   dcu, acu;

    // per collector: which banks it wants, with the lowest waiting slot per bank
    always_comb begin
        for (int c = 0; c < NUM_CU; c++) begin
            busy_v[c]   = st_q.cu[c].busy;
            done_v[c]   = st_q.cu[c].busy;
            oldest_v[c] = st_q.cu[c].busy && (st_q.cu[c].age == '0);
            for (int s = 0; s < NUM_SLOTS; s++)
                if (st_q.cu[c].slot[s].vld && !st_q.cu[c].slot[s].rdy) done_v[c] = 1'b0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                req[b][c]   = 1'b0;
                rslot[c][b] = '0;
                for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
                    if (st_q.cu[c].busy && st_q.cu[c].slot[s].vld &&
                        !st_q.cu[c].slot[s].rdy && !st_q.cu[c].slot[s].pend &&
                        bank_of(st_q.cu[c].warp, st_q.cu[c].slot[s].rnum) == BANK_W'(b)) begin
                        req[b][c]   = 1'b1;
                        rslot[c][b] = SLOT_W'(s);
                    end
                end
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        oc_rr_arb #(.N(NUM_CU)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req[b]),
            .gnt_any (gany[b]),
            .gnt_idx (gcu[b])
        );

        oc_bank_port u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (gany[b]),
            .rd_cu   (gcu[b]),
            .rd_slot (rslot[gcu[b]][b]),
            .rd_warp (st_q.cu[gcu[b]].warp),
            .rd_reg  (st_q.cu[gcu[b]].slot[rslot[gcu[b]][b]].rnum),
            .ret_q   (ret[b])
        );

        // R5: returned data always lands in a slot that is waiting for it
        assert_return_to_waiting_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ret[b].vld |-> (st_q.cu[ret[b].cu].busy &&
                            st_q.cu[ret[b].cu].slot[ret[b].slot].pend &&
                            !st_q.cu[ret[b].cu].slot[ret[b].slot].rdy));
    end

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;

        // granted slots wait for their data
        for (int b = 0; b < NUM_BANKS; b++)
            if (gany[b]) st_d.cu[gcu[b]].slot[rslot[gcu[b]][b]].pend = 1'b1;

        // data from last cycle's grants fills the slots
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (ret[b].vld) begin
                st_d.cu[ret[b].cu].slot[ret[b].slot].data = ret[b].data;
                st_d.cu[ret[b].cu].slot[ret[b].slot].rdy  = 1'b1;
                st_d.cu[ret[b].cu].slot[ret[b].slot].pend = 1'b0;
            end
        end

        // oldest complete collector leaves
        dsp = 1'b0;
        dcu = '0;
        for (int c = 0; c < NUM_CU; c++) begin
            if (done_v[c] && (!dsp || st_q.cu[c].age < st_q.cu[dcu].age)) begin
                dsp = 1'b1;
                dcu = CU_W'(c);
            end
        end
        if (dsp) begin
            st_d.ov    = 1'b1;
            st_d.otag  = st_q.cu[dcu].tag;
            st_d.owarp = st_q.cu[dcu].warp;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                st_d.osrcv[s] = st_q.cu[dcu].slot[s].vld;
                st_d.oops[s*DATA_W +: DATA_W] = st_q.cu[dcu].slot[s].data;
            end
            st_d.cu[dcu].busy = 1'b0;
            for (int c = 0; c < NUM_CU; c++)
                if (st_q.cu[c].busy && st_q.cu[c].age > st_q.cu[dcu].age)
                    st_d.cu[c].age = st_q.cu[c].age - 1'b1;
        end

        // a new instruction takes the lowest free collector
        take = in_valid && in_ready;
        acu  = '0;
        for (int c = NUM_CU - 1; c >= 0; c--)
            if (!busy_v[c]) acu = CU_W'(c);
        if (take) begin
            st_d.cu[acu].busy = 1'b1;
            st_d.cu[acu].warp = in_warp;
            st_d.cu[acu].tag  = in_tag;
            st_d.cu[acu].age  = CU_W'($countones(busy_v)) - CU_W'(dsp);
            for (int s = 0; s < NUM_SLOTS; s++) begin
                st_d.cu[acu].slot[s].vld  = in_src_valid[s];
                st_d.cu[acu].slot[s].rdy  = 1'b0;
                st_d.cu[acu].slot[s].pend = 1'b0;
                st_d.cu[acu].slot[s].rnum = in_src_regs[s*REG_W +: REG_W];
                st_d.cu[acu].slot[s].data = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready      = ~&busy_v;
    assign out_valid     = st_q.ov;
    assign out_tag       = st_q.otag;
    assign out_warp      = st_q.owarp;
    assign out_src_valid = st_q.osrcv;
    assign out_ops       = st_q.oops;

    // R7, R8: nothing is taken while every collector is busy
    assert_no_take_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> ($countones(busy_v) <= $past($countones(busy_v))));
    // R9: exactly one oldest collector whenever any is busy
    assert_single_oldest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|busy_v) |-> ($countones(oldest_v) == 1));
endmodule

// File: tb/sim_oc_collector_top.sv
module sim_oc_collector_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_warp = '0;
    logic [3:0]  in_tag = '0;
    logic [2:0]  in_src_valid = '0;
    logic [11:0] in_src_regs = '0;
    logic        out_valid;
    logic [3:0]  out_tag;
    logic [1:0]  out_warp;
    logic [2:0]  out_src_valid;
    logic [95:0] out_ops;

    always #5 clk = ~clk;

    oc_collector_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_warp(in_warp), .in_tag(in_tag), .in_src_valid(in_src_valid),
        .in_src_regs(in_src_regs), .out_valid(out_valid), .out_tag(out_tag),
        .out_warp(out_warp), .out_src_valid(out_src_valid), .out_ops(out_ops)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_out = 0;
    int acc_cyc [16];
    logic [3:0]  rec_tag  [64];
    int          rec_cyc  [64];
    logic [1:0]  rec_warp [64];
    logic [2:0]  rec_srcv [64];
    logic [95:0] rec_ops  [64];

    // {warp, valid mask, r0, r1, r2, tag, expected latency}
    localparam logic [24:0] VEC [10] = '{
        {2'd0, 3'b111, 4'd1,  4'd2, 4'd3, 4'd1,  4'd3},
        {2'd1, 3'b111, 4'd0,  4'd1, 4'd2, 4'd2,  4'd3},
        {2'd0, 3'b111, 4'd0,  4'd4, 4'd8, 4'd3,  4'd5},
        {2'd2, 3'b011, 4'd2,  4'd6, 4'd9, 4'd4,  4'd4},
        {2'd3, 3'b000, 4'd1,  4'd2, 4'd3, 4'd5,  4'd1},
        {2'd1, 3'b101, 4'd3,  4'd8, 4'd7, 4'd6,  4'd4},
        {2'd2, 3'b111, 4'd5,  4'd5, 4'd5, 4'd7,  4'd5},
        {2'd3, 3'b001, 4'd15, 4'd0, 4'd0, 4'd8,  4'd3},
        {2'd0, 3'b110, 4'd9,  4'd1, 4'd2, 4'd9,  4'd3},
        {2'd1, 3'b111, 4'd3,  4'd4, 4'd7, 4'd10, 4'd4}
    };

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid && n_out < 64) begin
            rec_tag[n_out]  = out_tag;
            rec_cyc[n_out]  = cyc;
            rec_warp[n_out] = out_warp;
            rec_srcv[n_out] = out_src_valid;
            rec_ops[n_out]  = out_ops;
            n_out++;
        end
    end

    function automatic logic [31:0] rv(input logic [1:0] w, input logic [3:0] r);
        return {26'd0, w, r} * 32'h0103_0507;
    endfunction

    function automatic logic [95:0] exp_ops(input logic [1:0] w, input logic [2:0] m,
                                            input logic [3:0] r0, input logic [3:0] r1,
                                            input logic [3:0] r2);
        return {m[2] ? rv(w, r2) : 32'd0, m[1] ? rv(w, r1) : 32'd0, m[0] ? rv(w, r0) : 32'd0};
    endfunction

    function automatic int find(input logic [3:0] t, input int from);
        for (int i = from; i < n_out; i++) if (rec_tag[i] == t) return i;
        return -1;
    endfunction

    function automatic int cnt(input logic [3:0] t, input int from);
        int n;
        n = 0;
        for (int i = from; i < n_out; i++) if (rec_tag[i] == t) n++;
        return n;
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // called at a falling edge; the instruction is taken at the next rising edge
    task automatic issue(input logic [1:0] w, input logic [2:0] m, input logic [3:0] r0,
                         input logic [3:0] r1, input logic [3:0] r2, input logic [3:0] t);
        while (!in_ready) @(negedge clk);
        in_valid     = 1'b1;
        in_warp      = w;
        in_src_valid = m;
        in_src_regs  = {r2, r1, r0};
        in_tag       = t;
        acc_cyc[t]   = cyc + 1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base;
        int idx;
        repeat (3) @(negedge clk);
        chk("R1", "in_ready in reset", 96'(in_ready), 96'd1);
        chk("R1", "out_valid in reset", 96'(out_valid), 96'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "in_ready after reset", 96'(in_ready), 96'd1);
        chk("R1", "no dispatch after reset", 96'(n_out), 96'd0);

        // table walk: one instruction at a time, latency and operands
        for (int v = 0; v < 10; v++) begin
            logic [24:0] e;
            e = VEC[v];
            base = n_out;
            issue(e[24:23], e[22:20], e[19:16], e[15:12], e[11:8], e[7:4]);
            repeat (12) @(negedge clk);
            chk("R9", $sformatf("vec %0d dispatched once", v), 96'(cnt(e[7:4], base)), 96'd1);
            idx = find(e[7:4], base);
            if (idx >= 0) begin
                chk("R5", $sformatf("vec %0d latency (bank spread R2)", v),
                    96'(rec_cyc[idx] - acc_cyc[e[7:4]]), 96'(e[3:0]));
                chk("R6", $sformatf("vec %0d operands (contents R3)", v), rec_ops[idx],
                    exp_ops(e[24:23], e[22:20], e[19:16], e[15:12], e[11:8]));
                chk("R9", $sformatf("vec %0d warp and slot flags", v),
                    96'({rec_warp[idx], rec_srcv[idx]}), 96'({e[24:23], e[22:20]}));
            end
        end

        // R8 and R7: fill all collectors, offer a fifth that must be refused
        base = n_out;
        for (int k = 1; k <= 4; k++) issue(2'd0, 3'b111, 4'd0, 4'd4, 4'd8, 4'(k));
        chk("R8", "in_ready low with four held", 96'(in_ready), 96'd0);
        in_valid = 1'b1; in_tag = 4'd15; in_src_valid = 3'b000; in_warp = 2'd0;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (40) @(negedge clk);
        chk("R7", "refused offer never dispatched", 96'(cnt(4'd15, base)), 96'd0);
        chk("R8", "four dispatched", 96'(n_out - base), 96'd4);
        for (int k = 1; k <= 4; k++) begin
            idx = find(4'(k), base);
            chk("R2", $sformatf("full-load instr %0d present", k), 96'(idx >= 0), 96'd1);
            if (idx >= 0)
                chk("R3", $sformatf("full-load instr %0d operands", k), rec_ops[idx],
                    exp_ops(2'd0, 3'b111, 4'd0, 4'd4, 4'd8));
        end
        chk("R7", "in_ready high after drain", 96'(in_ready), 96'd1);

        // R4: two collectors fight for bank 0 and must alternate
        base = n_out;
        issue(2'd0, 3'b111, 4'd0, 4'd4, 4'd8, 4'd11);
        issue(2'd0, 3'b111, 4'd12, 4'd0, 4'd4, 4'd12);
        repeat (15) @(negedge clk);
        idx = find(4'd11, base);
        chk("R4", "first contender latency", 96'(idx >= 0 ? rec_cyc[idx] - acc_cyc[11] : -1), 96'd7);
        idx = find(4'd12, base);
        chk("R4", "second contender latency", 96'(idx >= 0 ? rec_cyc[idx] - acc_cyc[12] : -1), 96'd7);

        // R9: two collectors complete together, the older leaves first
        base = n_out;
        issue(2'd0, 3'b011, 4'd0, 4'd4, 4'd0, 4'd13);
        issue(2'd0, 3'b001, 4'd1, 4'd0, 4'd0, 4'd14);
        repeat (12) @(negedge clk);
        idx = find(4'd13, base);
        chk("R9", "older latency", 96'(idx >= 0 ? rec_cyc[idx] - acc_cyc[13] : -1), 96'd4);
        idx = find(4'd14, base);
        chk("R9", "younger latency", 96'(idx >= 0 ? rec_cyc[idx] - acc_cyc[14] : -1), 96'd4);
        chk("R9", "older is first record", 96'(rec_tag[base]), 96'd13);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule